// File: doc/BRIEF.md
# Transmit Word Formatter with In-Band Port Address

This block takes 40-bit words from a transmit buffer and turns each one into a word for a 32-bit packet transmit bus. The top bit of each stored word tells the block what kind of word it is. When that bit is clear, the word is payload, and its low 32 bits pass straight to the bus. When that bit is set, the word holds a port number. The block then drives only the port field onto the bus and raises a start-of-transfer qualifier, so the device on the far side can see which port the following burst belongs to.

A configuration input gives the width of the port field: 2, 4 or 8 ports. On an address word, every data bit above the port field is driven to zero. This includes the two bits just above the field, which a receiver could otherwise misread as part of the address.

Every word that goes out carries a parity bit over its 32 data bits. The parity sense, even or odd, can be chosen on any cycle. All outputs are registered, with one cycle of latency, and come with a valid qualifier.

Top module: `txw_fmt`

## Requirements
- R1: While reset is asserted and right after it, `out_valid`, `out_start`, `out_par` and `out_data` are all zero.
- R2: `out_valid` on the cycle after each rising clock edge equals `in_valid` sampled at that edge, so the latency is exactly one cycle.
- R3: When a valid word has bit 39 equal to 0, `out_data` on the next cycle equals bits [31:0] of that word, and `out_start` is 0.
- R4: When a valid word has bit 39 equal to 1, `out_start` is 1 on the next cycle.
- R5: For an address word with `port_cfg` = 2'b00 (2 ports), `out_data[0]` equals bit 0 of the word and `out_data[31:1]` are all zero.
- R6: For an address word with `port_cfg` = 2'b01 (4 ports), `out_data[1:0]` equal bits [1:0] of the word and `out_data[31:2]` are all zero.
- R7: For an address word with `port_cfg` = 2'b10 or 2'b11 (8 ports), `out_data[2:0]` equal bits [2:0] of the word, `out_data[4:3]` are zero and `out_data[31:5]` are zero.
- R8: With `odd_par` = 0 when the word is accepted, the 32 bits of `out_data` plus `out_par` together hold an even number of ones.
- R9: With `odd_par` = 1 when the word is accepted, the 32 bits of `out_data` plus `out_par` together hold an odd number of ones.
- R10: After a cycle with `in_valid` = 0, `out_valid` and `out_start` are 0, and `out_data` and `out_par` keep the values they had.
- R11: Bits [38:32] of a stored word have no effect on `out_data` or `out_par`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A buffer word is present this cycle |
| in_word | input | 40 | Stored word; bit 39 marks a port-address word |
| port_cfg | input | 2 | Port-field width: 00 = 1 bit, 01 = 2 bits, 1x = 3 bits |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| out_valid | output | 1 | The output word is valid |
| out_data | output | 32 | Transmit data bus |
| out_start | output | 1 | Start-of-transfer qualifier, high on address words |
| out_par | output | 1 | Parity bit over `out_data` |

## Verification
The bench sends address words whose upper bits are all ones. It does this under each port setting, including the duplicate 8-port code. A design that masked too few bits, or masked off by one, would let ones into bits [4:3] or higher, and would get wrong port values. Payload words carry ones in bits [38:32]. Some payload words have bits [2:0] set, to catch a design that leaks masking or the start qualifier into payload words. Parity is checked with both senses, and with the sense flipped between back-to-back words, so that inverted or stale parity shows up. An idle cycle follows a word, to catch a start qualifier that sticks high or data that is not held.

// File: rtl/txw_fmt.sv
module txw_fmt #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [1:0]        port_cfg,
  input  logic              odd_par,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_start,
  output logic              out_par
);
  localparam int FLAG_BIT = WORD_W - 1;

  logic [DATA_W-1:0] port_mask;
  logic [DATA_W-1:0] next_data;
  logic              is_addr;

  always_comb begin
    unique case (port_cfg)
      2'b00:   port_mask = DATA_W'(1);
      2'b01:   port_mask = DATA_W'(3);
      default: port_mask = DATA_W'(7);
    endcase
  end

  assign is_addr   = in_word[FLAG_BIT];
  assign next_data = is_addr ? (in_word[DATA_W-1:0] & port_mask) : in_word[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_start <= 1'b0;
      out_par   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= next_data;
        out_start <= is_addr;
        out_par   <= (^next_data) ^ odd_par;
      end else begin
        out_start <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txw_fmt_chk.sv
module txw_fmt_chk #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic [1:0]        port_cfg,
  input logic              odd_par,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_start,
  input logic              out_par
);
  localparam int FLAG_BIT = WORD_W - 1;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_payload_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_word[FLAG_BIT]) |=> (out_data == $past(in_word[DATA_W-1:0]) && !out_start));
  p_addr_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[FLAG_BIT]) |=> out_start);
  p_mask2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[FLAG_BIT] && port_cfg == 2'b00) |=>
      (out_data[DATA_W-1:1] == '0 && out_data[0] == $past(in_word[0])));
  p_mask4_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[FLAG_BIT] && port_cfg == 2'b01) |=>
      (out_data[DATA_W-1:2] == '0 && out_data[1:0] == $past(in_word[1:0])));
  p_mask8_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[FLAG_BIT] && port_cfg[1]) |=>
      (out_data[DATA_W-1:3] == '0 && out_data[2:0] == $past(in_word[2:0])));
  p_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !odd_par) |=> ($countones({out_data, out_par}) % 2 == 0));
  p_odd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && odd_par) |=> ($countones({out_data, out_par}) % 2 == 1));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=> (!out_start && $stable(out_data) && $stable(out_par)));
  p_start_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);
endmodule

bind txw_fmt txw_fmt_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .port_cfg(port_cfg), .odd_par(odd_par), .out_valid(out_valid),
  .out_data(out_data), .out_start(out_start), .out_par(out_par)
);

// File: tb/tb_txw_fmt.sv
`timescale 1ns/1ps
module tb_txw_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [39:0] in_word = '0;
  logic [1:0]  port_cfg = 2'b10;
  logic        odd_par = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_start;
  logic        out_par;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  txw_fmt dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .port_cfg(port_cfg), .odd_par(odd_par), .out_valid(out_valid),
    .out_data(out_data), .out_start(out_start), .out_par(out_par)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [31:0] d, input logic odd);
    return ($countones(d) % 2 == 1) ? ~odd : odd;
  endfunction

  task automatic send(input logic [39:0] w, input logic [1:0] cfg, input logic odd);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; port_cfg = cfg; odd_par = odd;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    in_valid = 1'b1; in_word = {1'b1, 39'h7F_FFFF_FFFF};
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid", 32'(out_valid), 0);
    chk("R1 start", 32'(out_start), 0);
    chk("R1 par", 32'(out_par), 0);
    chk("R1 data", out_data, 0);
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b1;
  endtask

  task automatic t_payload(input logic [39:0] w, input logic odd);
    send(w, 2'b10, odd);
    chk("R2 valid", 32'(out_valid), 1);
    chk("R3 data", out_data, w[31:0]);
    chk("R3 start", 32'(out_start), 0);
    chk(odd ? "R9 par" : "R8 par", 32'(out_par), 32'(exp_par(w[31:0], odd)));
  endtask

  task automatic t_addr(input logic [1:0] cfg, input logic [31:0] exp, input string req, input logic odd);
    send({1'b1, 7'h7F, 32'hFFFF_FFFF}, cfg, odd);
    chk("R4 start", 32'(out_start), 1);
    chk(req, out_data, exp);
    chk(odd ? "R9 addr par" : "R8 addr par", 32'(out_par), 32'(exp_par(exp, odd)));
  endtask

  task automatic t_addr_val(input logic [2:0] p);
    send({1'b1, 7'h55, 27'h5A5A5A5, 2'b11, p}, 2'b10, 1'b0);
    chk("R7 port value", out_data, {29'd0, p});
  endtask

  task automatic t_idle;
    logic [31:0] d;
    logic        pr;
    d = out_data; pr = out_par;
    @(negedge clk);
    in_valid = 1'b0; in_word = {1'b1, 39'h12_3456_789A}; odd_par = ~odd_par;
    @(posedge clk); #1;
    chk("R10 valid", 32'(out_valid), 0);
    chk("R10 start", 32'(out_start), 0);
    chk("R10 data hold", out_data, d);
    chk("R10 par hold", 32'(out_par), 32'(pr));
  endtask

  task automatic t_upper_ignored;
    logic [31:0] d0;
    logic        p0;
    send({1'b0, 7'h00, 32'h1234_5677}, 2'b10, 1'b0);
    d0 = out_data; p0 = out_par;
    send({1'b0, 7'h7F, 32'h1234_5677}, 2'b10, 1'b0);
    chk("R11 data", out_data, d0);
    chk("R11 par", 32'(out_par), 32'(p0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_payload({1'b0, 7'h7F, 32'hDEAD_BEEF}, 1'b0);
    t_payload({1'b0, 7'h2A, 32'h0000_0007}, 1'b1);
    t_payload({1'b0, 7'h00, 32'h8000_0001}, 1'b0);
    t_addr(2'b00, 32'h1, "R5 mask", 1'b0);
    t_addr(2'b01, 32'h3, "R6 mask", 1'b1);
    t_addr(2'b10, 32'h7, "R7 mask", 1'b0);
    t_addr(2'b11, 32'h7, "R7 mask cfg11", 1'b1);
    t_idle();
    for (int p = 0; p < 8; p++) t_addr_val(3'(p));
    t_payload({1'b0, 7'h01, 32'hFFFF_FFFF}, 1'b1);
    t_payload({1'b0, 7'h01, 32'hFFFF_FFFF}, 1'b0);
    t_idle();
    t_upper_ignored();
    @(negedge clk); in_valid = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule